// File: doc/BRIEF.md
# SPI Slave Hold/Pause Controller

This block sits between the pins of a serial peripheral interface and the shift logic of a slave device. It samples chip select, serial clock, the active-low hold request and serial data in on a fast system clock. From these it produces four things for the downstream bit and byte logic: a shift enable, one-cycle pulses that mark qualified serial clock edges, a registered sample of the data input, and a force-high-impedance control for the serial output driver.

The hold request suspends a transaction without losing its place. A change on the hold input takes effect only while the serial clock is low. If the change arrives while the clock is high, it waits until the clock next falls. While paused, the serial clock may keep toggling. No edge pulse is issued, the data input is not sampled and the output driver is forced off. When the transaction resumes, the shift logic continues from the bit where it stopped, and no new transaction start is signalled. Raising chip select while paused ends the transaction and clears the pause.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, and whenever chip select is high, the block holds shift_en=0, so_hiz=1 and paused=0, and issues no edge pulses.
- R2: Chip select going low gives a single one-cycle txn_start pulse. shift_en goes to 1 in the following cycle.
- R3: While running, each rising serial clock edge gives exactly one sck_rise_q pulse and each falling edge gives exactly one sck_fall_q pulse. si_bit takes the level of spi_si on the cycle after each sck_rise_q pulse. Bits are taken MSB first by the downstream logic, and this holds with the clock idling either low or high.
- R4: spi_hold_n low while spi_sck is low puts the block in pause: paused=1, shift_en=0, so_hiz=1.
- R5: spi_hold_n going low while spi_sck is high does not pause the block until spi_sck falls. That falling edge is still delivered as an sck_fall_q pulse.
- R6: While paused, serial clock edges give no sck_rise_q or sck_fall_q pulses, and si_bit does not change whatever spi_si does.
- R7: The pause ends only when spi_hold_n is high while spi_sck is low. spi_hold_n rising while spi_sck is high leaves the block paused until spi_sck falls.
- R8: Leaving the pause gives no txn_start pulse. The bits that follow extend the byte under way, so a byte split by a pause is received whole.
- R9: Chip select going high ends the transaction with a single one-cycle txn_end pulse. This also applies while paused, and it clears the pause.
- R10: sck_rise_q and sck_fall_q are never high in the same cycle, and serial clock toggling while chip select is high gives no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select pin, active low |
| spi_sck | input | 1 | Serial clock pin |
| spi_hold_n | input | 1 | Hold request pin, active low |
| spi_si | input | 1 | Serial data in pin |
| shift_en | output | 1 | Downstream shift logic may advance |
| sck_rise_q | output | 1 | One-cycle pulse on a qualified rising serial clock edge |
| sck_fall_q | output | 1 | One-cycle pulse on a qualified falling serial clock edge |
| si_bit | output | 1 | Data-in level captured at the last qualified rising edge |
| so_hiz | output | 1 | Force the serial output driver to high impedance |
| paused | output | 1 | Transaction is suspended by the hold request |
| txn_start | output | 1 | One-cycle pulse when a transaction begins |
| txn_end | output | 1 | One-cycle pulse when a transaction ends |

## Verification
The hardest cases to reach are the deferred transitions, where the hold input moves while the serial clock is high. For entry, the falling clock edge that follows must still count. For exit, the falling edge that releases the pause must not count. The stimulus reaches both by moving the hold pin in the middle of the clock-high phase. It then checks the pause level before and after the next falling clock edge. A sweep places a pause before every bit position of several byte patterns and toggles the clock and data-in during each pause. The reassembled byte and the edge counts show that no pulse leaked through and that none was lost.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

    typedef enum logic [1:0] {
        LNK_IDLE  = 2'd0,
        LNK_RUN   = 2'd1,
        LNK_PAUSE = 2'd2
    } link_state_e;

    typedef struct packed {
        logic cs_n;
        logic sck;
        logic hold_n;
        logic si;
    } pin_bundle_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } sck_edge_t;

    localparam int PIN_COUNT = $bits(pin_bundle_t);

    localparam pin_bundle_t PIN_IDLE = '{cs_n: 1'b1, sck: 1'b0, hold_n: 1'b1, si: 1'b0};

    // Hold changes are only honoured while the serial clock is low.
    function automatic logic hold_window(input logic sck_lvl);
        return !sck_lvl;
    endfunction

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
    parameter int                   WIDTH     = 4,
    parameter int                   STAGES    = 2,
    parameter logic [WIDTH-1:0]     RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RESET_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge
    import spi_hold_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sck_lvl,
    output sck_edge_t ev
);
    logic sck_prev;

    always_ff @(posedge clk) begin
        if (rst) sck_prev <= PIN_IDLE.sck;
        else     sck_prev <= sck_lvl;
    end

    always_comb begin
        ev.rise = sck_lvl & ~sck_prev;
        ev.fall = ~sck_lvl & sck_prev;
    end
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
    import spi_hold_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n_lvl,
    input  logic        sck_lvl,
    input  logic        hold_n_lvl,
    output link_state_e state
);
    link_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            LNK_IDLE: begin
                if (!cs_n_lvl) state_nx = LNK_RUN;
            end
            LNK_RUN: begin
                if (cs_n_lvl)
                    state_nx = LNK_IDLE;
                else if (hold_window(sck_lvl) && !hold_n_lvl)
                    state_nx = LNK_PAUSE;
            end
            LNK_PAUSE: begin
                if (cs_n_lvl)
                    state_nx = LNK_IDLE;
                else if (hold_window(sck_lvl) && hold_n_lvl)
                    state_nx = LNK_RUN;
            end
            default: state_nx = LNK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= LNK_IDLE;
        else     state <= state_nx;
    end
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
    import spi_hold_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_hold_n,
    input  logic spi_si,
    output logic shift_en,
    output logic sck_rise_q,
    output logic sck_fall_q,
    output logic si_bit,
    output logic so_hiz,
    output logic paused,
    output logic txn_start,
    output logic txn_end
);
    pin_bundle_t pins_raw;
    pin_bundle_t pins_s;
    sck_edge_t   sck_ev;
    link_state_e state;

    logic cs_n_s;
    logic sck_s;
    logic hold_n_s;
    logic si_s;

    always_comb begin
        pins_raw.cs_n   = spi_cs_n;
        pins_raw.sck    = spi_sck;
        pins_raw.hold_n = spi_hold_n;
        pins_raw.si     = spi_si;
    end

    spi_hold_sync #(
        .WIDTH    (PIN_COUNT),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(PIN_IDLE)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (pins_raw),
        .q  (pins_s)
    );

    assign cs_n_s   = pins_s.cs_n;
    assign sck_s    = pins_s.sck;
    assign hold_n_s = pins_s.hold_n;
    assign si_s     = pins_s.si;

    spi_hold_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sck_lvl(sck_s),
        .ev     (sck_ev)
    );

    spi_hold_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cs_n_lvl  (cs_n_s),
        .sck_lvl   (sck_s),
        .hold_n_lvl(hold_n_s),
        .state     (state)
    );

    always_comb begin
        shift_en   = (state == LNK_RUN) && !cs_n_s;
        sck_rise_q = sck_ev.rise && shift_en;
        sck_fall_q = sck_ev.fall && shift_en;
        so_hiz     = !shift_en;
        paused     = (state == LNK_PAUSE);
        txn_start  = (state == LNK_IDLE) && !cs_n_s;
        txn_end    = (state != LNK_IDLE) && cs_n_s;
    end

    always_ff @(posedge clk) begin
        if (rst)             si_bit <= 1'b0;
        else if (sck_rise_q) si_bit <= si_s;
    end
endmodule

// File: rtl/spi_hold_checker.sv
module spi_hold_checker (
    input logic clk,
    input logic rst,
    input logic cs_n_s,
    input logic sck_s,
    input logic hold_n_s,
    input logic shift_en,
    input logic sck_rise_q,
    input logic sck_fall_q,
    input logic so_hiz,
    input logic paused,
    input logic txn_start,
    input logic txn_end
);
    p_quiet_cs_high_r1: assert property (@(posedge clk) disable iff (rst)
        $past(cs_n_s) && cs_n_s |-> !shift_en && so_hiz && !paused);

    p_start_single_r2: assert property (@(posedge clk) disable iff (rst)
        txn_start |=> !txn_start);

    p_pause_hiz_r4: assert property (@(posedge clk) disable iff (rst)
        paused |-> so_hiz && !shift_en);

    p_enter_low_sck_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(paused) |-> !$past(sck_s) && !$past(hold_n_s));

    p_no_edges_paused_r6: assert property (@(posedge clk) disable iff (rst)
        paused |-> !sck_rise_q && !sck_fall_q);

    p_exit_low_sck_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(paused) && !$past(cs_n_s) |-> !$past(sck_s) && $past(hold_n_s));

    p_resume_no_start_r8: assert property (@(posedge clk) disable iff (rst)
        $past(paused) && !paused |-> !txn_start);

    p_end_clears_r9: assert property (@(posedge clk) disable iff (rst)
        txn_end |=> !paused && !shift_en && !txn_end);

    p_edge_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        !(sck_rise_q && sck_fall_q));
endmodule

bind spi_hold_ctrl spi_hold_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n_s    (cs_n_s),
    .sck_s     (sck_s),
    .hold_n_s  (hold_n_s),
    .shift_en  (shift_en),
    .sck_rise_q(sck_rise_q),
    .sck_fall_q(sck_fall_q),
    .so_hiz    (so_hiz),
    .paused    (paused),
    .txn_start (txn_start),
    .txn_end   (txn_end)
);

// File: tb/tb_spi_hold_ctrl.sv
module tb_spi_hold_ctrl;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_hold_n = 1'b1, spi_si = 1'b0;
    logic shift_en, sck_rise_q, sck_fall_q, si_bit, so_hiz, paused, txn_start, txn_end;

    int n_chk = 0, n_fail = 0;
    int n_rise = 0, n_fall = 0, n_start = 0, n_end = 0;
    logic [7:0] rx = '0;
    logic rise_seen = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spi_hold_ctrl dut (.*);

    always @(negedge clk) begin
        if (rst) begin
            rise_seen <= 1'b0;
        end else begin
            if (rise_seen) rx <= {rx[6:0], si_bit};
            rise_seen <= sck_rise_q;
            if (sck_rise_q) n_rise <= n_rise + 1;
            if (sck_fall_q) n_fall <= n_fall + 1;
            if (txn_start)  n_start <= n_start + 1;
            if (txn_end)    n_end <= n_end + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // one mode-0 bit: data set while clock low, then a full clock pulse
    task automatic bit0(input logic b);
        spi_si = b;  wt(H);
        spi_sck = 1; wt(H);
        spi_sck = 0; wt(H);
    endtask

    // pause at the current low clock, toggle clock and data, resume
    task automatic pause_and_jitter(input logic last_b);
        logic kept;
        spi_hold_n = 0; wt(H);
        chk("R4 paused", paused, 1);
        chk("R4 so_hiz", so_hiz, 1);
        kept = si_bit;
        for (int k = 0; k < 3; k++) begin
            spi_si = ~last_b; spi_sck = 1; wt(H);
            spi_sck = 0; wt(H);
        end
        chk("R6 si_bit kept", si_bit, kept);
        spi_hold_n = 1; wt(H);
        chk("R7 resumed", paused, 0);
    endtask

    task automatic xfer(input logic [7:0] b, input int hp, input bit do_hold);
        int r0, f0, s0, e0;
        r0 = n_rise; f0 = n_fall; s0 = n_start; e0 = n_end;
        spi_cs_n = 0; wt(H);
        for (int i = 7; i >= 0; i--) begin
            if (do_hold && (7 - i) == hp)
                pause_and_jitter((i == 7) ? 1'b0 : b[i+1]);
            bit0(b[i]);
        end
        spi_cs_n = 1; wt(H);
        chk("R3 byte", rx, b);
        chk("R6 rise count", n_rise - r0, 8);
        chk("R6 fall count", n_fall - f0, 8);
        chk("R8 single start", n_start - s0, 1);
        chk("R9 single end", n_end - e0, 1);
    endtask

    initial begin
        wt(4);
        rst = 0; wt(2);
        chk("R1 shift_en", shift_en, 0);
        chk("R1 so_hiz", so_hiz, 1);
        chk("R1 paused", paused, 0);

        // R2 start and R3 plain byte
        spi_cs_n = 0; wt(H);
        chk("R2 start", n_start, 1);
        chk("R2 shift_en", shift_en, 1);
        for (int i = 7; i >= 0; i--) bit0(8'hA5 >> i);
        chk("R3 byte A5", rx, 8'hA5);
        chk("R3 rises", n_rise, 8);
        chk("R3 falls", n_fall, 8);

        // R5 deferred entry
        spi_si = 1; wt(H);
        spi_sck = 1; wt(H);
        spi_hold_n = 0; wt(H);
        chk("R5 not yet paused", paused, 0);
        spi_sck = 0; wt(H);
        chk("R5 fall delivered", n_fall, 9);
        chk("R5 paused after fall", paused, 1);

        // R7 deferred exit
        spi_sck = 1; wt(H);
        spi_hold_n = 1; wt(H);
        chk("R7 still paused", paused, 1);
        spi_sck = 0; wt(H);
        chk("R7 resumed", paused, 0);
        chk("R7 no fall in pause", n_fall, 9);
        chk("R6 no rise in pause", n_rise, 9);

        // R9 end while paused
        spi_hold_n = 0; wt(H);
        chk("R9 pre paused", paused, 1);
        spi_cs_n = 1; wt(H);
        chk("R9 end", n_end, 1);
        chk("R9 pause cleared", paused, 0);
        chk("R9 so_hiz", so_hiz, 1);
        spi_hold_n = 1; wt(H);

        // R10 clock activity with CS high
        for (int k = 0; k < 4; k++) begin
            spi_sck = 1; wt(H); spi_sck = 0; wt(H);
        end
        chk("R10 no rise", n_rise, 9);
        chk("R10 no fall", n_fall, 9);
        chk("R1 idle shift_en", shift_en, 0);

        // R8 sweep: pause before every bit position
        for (int p = 0; p < 8; p++) begin
            xfer(8'h3C, p, 1);
            xfer(8'hC3 ^ p[7:0], p, 1);
            xfer(8'h01 << p, p, 1);
            xfer(8'hFF, p, 1);
        end

        // R3 clock idling high
        begin
            int r0;
            r0 = n_rise;
            spi_sck = 1; wt(H);
            spi_cs_n = 0; wt(H);
            for (int i = 7; i >= 0; i--) begin
                spi_sck = 0; wt(H);
                spi_si = 8'h6D >> i; wt(H);
                spi_sck = 1; wt(H);
            end
            spi_cs_n = 1; wt(H);
            chk("R3 idle-high byte", rx, 8'h6D);
            chk("R3 idle-high rises", n_rise - r0, 8);
            spi_sck = 0; wt(H);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule